// File: doc/BRIEF.md
# Paged Digital I/O Register Bank

This block is the byte-wide register file of a 48-line digital I/O chip. A host reaches it through a 4-bit address with separate write and read strobes. Six port registers control 48 open-drain lines. A 1 in a port bit makes the line sink current. A 0 releases the line so that an outside agent can drive it. Reading a port returns the inverted level of the pins.

A shared control byte holds a 2-bit page selector and one write-lock bit per port. The page selector decides what the three window offsets 8 to 10 address: the edge-polarity bank, the interrupt-enable bank or the interrupt-identification bank. These banks drive a separate capture unit. That unit reports detected edges back on a set input, and the set input ORs into the identification bank. A read-only pending byte summarises the identification bank, one bit per byte.

Top module: `paged_dio_bank`

## Requirements
- R1: After reset, every pad output enable, every polarity, enable and identification bit, the page field and all lock bits are 0. A read of offset 7 returns 0x00.
- R2: A write to offset p (0 to 5) whose lock bit is clear loads `pad_oe[8p+7:8p]`, whatever page is selected. A 1 bit enables the line's low drive. `pad_out` is always all zeros.
- R3: While bit p of offset 7 is 1, writes to offset p leave `pad_oe[8p+7:8p]` unchanged. Reads of that port still work.
- R4: A read of offset p (0 to 5) returns the bitwise inverse of `pad_in[8p+7:8p]`.
- R5: Offset 7 stores the page in bits 7:6 and the per-port lock bits in bits 5:0, and it reads back as written.
- R6: Offsets 8, 9 and 10 address byte 0, 1 and 2 of the 24-bit bank chosen by the page: page 1 is `pol`, page 2 is `enab`, page 3 is `int_id`. Byte k covers bits 8k+7:8k. These offsets read back the selected bank.
- R7: On page 0, offsets 8 to 10 read as 0x00 and writes to them change nothing. Offsets 11 to 15 always read 0x00 and ignore writes.
- R8: Every cycle, each 1 bit on `irq_set` sets the matching `int_id` bit. When a host write to the identification bank lands in the same cycle, the written byte is ORed with `irq_set`, so no set is lost.
- R9: Offset 6 is read-only. Its bit k (k = 0 to 2) is the OR of `int_id` byte k, and bits 7:3 read 0. Writes to offset 6 have no effect.
- R10: `rdata` shows, one cycle after a cycle with `rd` high, the value addressed in that cycle as it stood before that clock edge. After a cycle with `rd` low, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Pin levels |
| pad_oe | output | 48 | Per-line low-drive enable |
| pad_out | output | 48 | Driven level (always low) |
| irq_set | input | 24 | Edge reports from the capture unit |
| pol | output | 24 | Polarity bank |
| enab | output | 24 | Enable bank |
| int_id | output | 24 | Identification bank |

## Verification
Two events can fall in the same cycle. A host write to the identification bank, typically a clear with 0x00, can coincide with a capture-unit set on `irq_set`. The bench forces this by pulsing `irq_set` in the very cycle of a page-3 clear, then expects the set bit to survive while the other bits clear. A read can also coincide with a write to the same offset; there the read must return the old value. The random phase produces both cases repeatedly, and the behavioural model judges them every clock.

// File: rtl/paged_dio_bank.sv
module paged_dio_bank #(
  parameter int PORTS = 6,
  parameter int WIN   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         addr,
  input  logic [7:0]         wdata,
  input  logic               wr,
  input  logic               rd,
  output logic [7:0]         rdata,
  input  logic [PORTS*8-1:0] pad_in,
  output logic [PORTS*8-1:0] pad_oe,
  output logic [PORTS*8-1:0] pad_out,
  input  logic [WIN*8-1:0]   irq_set,
  output logic [WIN*8-1:0]   pol,
  output logic [WIN*8-1:0]   enab,
  output logic [WIN*8-1:0]   int_id
);
  localparam int LINES = PORTS * 8;
  localparam int WBITS = WIN * 8;
  localparam logic [3:0] A_PEND = 4'd6;
  localparam logic [3:0] A_CTRL = 4'd7;
  localparam logic [3:0] A_WIN  = 4'd8;

  logic [LINES-1:0] port_q;
  logic [7:0]       ctrl_q;
  logic [WBITS-1:0] pol_q, en_q, id_q, id_d;
  logic [7:0]       rdata_q, rsel;
  logic [WIN-1:0]   pend;
  logic [1:0]       page;

  assign page    = ctrl_q[7:6];
  assign pad_oe  = port_q;
  assign pad_out = '0;
  assign pol     = pol_q;
  assign enab    = en_q;
  assign int_id  = id_q;
  assign rdata   = rdata_q;

  always_comb begin
    for (int k = 0; k < WIN; k++) pend[k] = |id_q[k*8 +: 8];
  end

  always_comb begin
    id_d = id_q;
    for (int k = 0; k < WIN; k++)
      if (wr && page == 2'd3 && addr == A_WIN + 4'(k)) id_d[k*8 +: 8] = wdata;
    id_d = id_d | irq_set;
  end

  always_comb begin
    rsel = 8'h00;
    for (int p = 0; p < PORTS; p++)
      if (addr == 4'(p)) rsel = ~pad_in[p*8 +: 8];
    if (addr == A_PEND) rsel = 8'(pend);
    if (addr == A_CTRL) rsel = ctrl_q;
    for (int k = 0; k < WIN; k++)
      if (addr == A_WIN + 4'(k))
        case (page)
          2'd1:    rsel = pol_q[k*8 +: 8];
          2'd2:    rsel = en_q[k*8 +: 8];
          2'd3:    rsel = id_q[k*8 +: 8];
          default: rsel = 8'h00;
        endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q  <= '0;
      ctrl_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      id_q    <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd ? rsel : 8'h00;
      id_q    <= id_d;
      if (wr && addr == A_CTRL) ctrl_q <= wdata;
      for (int p = 0; p < PORTS; p++)
        if (wr && addr == 4'(p) && !ctrl_q[p]) port_q[p*8 +: 8] <= wdata;
      for (int k = 0; k < WIN; k++)
        if (wr && addr == A_WIN + 4'(k)) begin
          if (page == 2'd1) pol_q[k*8 +: 8] <= wdata;
          if (page == 2'd2) en_q[k*8 +: 8]  <= wdata;
        end
    end
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 4'd0 && !ctrl_q[0]) |=> (pad_oe[7:0] == $past(wdata)));

  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr < 4'(PORTS) && ctrl_q[addr[2:0]]) |=> $stable(pad_oe));

  a_r7_page0_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && page == 2'd0 && addr >= A_WIN) |=> ($stable(pol) && $stable(enab)));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set) |=> (($past(irq_set) & ~int_id) == '0));

  a_r9_pend_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_PEND) |=> (rdata[7:WIN] == '0));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == 8'h00));
endmodule

// File: tb/sim_paged_dio_bank.sv
`timescale 1ns/1ps
module sim_paged_dio_bank;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic        wr = 0, rd = 0;
  logic [7:0]  rdata;
  logic [47:0] pad_in = 0, pad_oe, pad_out;
  logic [23:0] irq_set = 0, pol, enab, int_id;

  paged_dio_bank u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .irq_set(irq_set), .pol(pol), .enab(enab), .int_id(int_id));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit run = 0, done = 0;

  logic [7:0] m_port [6];
  logic [7:0] m_ctrl, m_rd;
  logic [7:0] m_pol [3];
  logic [7:0] m_en [3];
  logic [7:0] m_id [3];

  function automatic logic [47:0] cat6(input logic [7:0] a [6]);
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = a[i];
    return v;
  endfunction
  function automatic logic [23:0] cat3(input logic [7:0] a [3]);
    logic [23:0] v;
    for (int i = 0; i < 3; i++) v[i*8 +: 8] = a[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_port[i] = 0;
      for (int i = 0; i < 3; i++) begin m_pol[i] = 0; m_en[i] = 0; m_id[i] = 0; end
      m_ctrl = 0; m_rd = 0;
    end else begin
      int a, pg;
      logic [7:0] v;
      a = addr; pg = m_ctrl[7:6]; v = 0;
      if (a < 6) v = ~pad_in[a*8 +: 8];
      else if (a == 6) for (int k = 0; k < 3; k++) v[k] = (m_id[k] != 0);
      else if (a == 7) v = m_ctrl;
      else if (a < 11) begin
        if (pg == 1) v = m_pol[a-8];
        if (pg == 2) v = m_en[a-8];
        if (pg == 3) v = m_id[a-8];
      end
      m_rd = rd ? v : 8'h00;
      if (wr) begin
        if (a < 6 && !m_ctrl[a]) m_port[a] = wdata;
        else if (a >= 8 && a < 11) begin
          if (pg == 1) m_pol[a-8] = wdata;
          if (pg == 2) m_en[a-8] = wdata;
          if (pg == 3) m_id[a-8] = wdata;
        end
        if (a == 7) m_ctrl = wdata;
      end
      for (int k = 0; k < 3; k++) m_id[k] = m_id[k] | irq_set[k*8 +: 8];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run) begin
    chk("R2 pad_oe", pad_oe, cat6(m_port));
    chk("R2 pad_out", pad_out, 48'h0);
    chk("R6 pol", pol, cat3(m_pol));
    chk("R6 enab", enab, cat3(m_en));
    chk("R8 int_id", int_id, cat3(m_id));
    chk("R10 rdata", rdata, m_rd);
  end

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1; rd = 0;
    @(negedge clk); wr = 0;
  endtask
  task automatic rreg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; rd = 1; wr = 0;
    @(negedge clk); rd = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; run = 1;
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 banks", {pol, enab, int_id}, 0);
    rreg("R1 ctrl", 4'd7, 8'h00);
    wreg(4'd0, 8'hA5);
    chk("R2 port0", pad_oe[7:0], 8'hA5);
    wreg(4'd5, 8'h3C);
    chk("R2 port5", pad_oe[47:40], 8'h3C);
    pad_in = 48'h0000_00F0_0000;
    rreg("R4 port2", 4'd2, 8'h0F);
    rreg("R4 port3", 4'd3, 8'hFF);
    wreg(4'd7, 8'h02);
    rreg("R5 ctrl", 4'd7, 8'h02);
    wreg(4'd1, 8'hFF);
    chk("R3 locked", pad_oe[15:8], 8'h00);
    rreg("R3 read locked", 4'd1, 8'hFF);
    wreg(4'd7, 8'h42);
    wreg(4'd8, 8'h11); wreg(4'd10, 8'h33);
    wreg(4'd0, 8'h5A);
    chk("R2 port any page", pad_oe[7:0], 8'h5A);
    rreg("R6 pol byte2", 4'd10, 8'h33);
    chk("R6 pol", pol, 24'h330011);
    wreg(4'd7, 8'h80);
    wreg(4'd9, 8'h77);
    chk("R6 enab", enab, 24'h007700);
    rreg("R6 enab byte1", 4'd9, 8'h77);
    wreg(4'd7, 8'h00);
    wreg(4'd9, 8'hEE);
    rreg("R7 page0 read", 4'd9, 8'h00);
    chk("R7 page0 write", {pol, enab}, {24'h330011, 24'h007700});
    wreg(4'd12, 8'hFF);
    rreg("R7 high offset", 4'd12, 8'h00);
    @(negedge clk); irq_set = 24'h010080;
    @(negedge clk); irq_set = 0;
    chk("R8 set", int_id, 24'h010080);
    wreg(4'd6, 8'hFF);
    rreg("R9 pending", 4'd6, 8'h05);
    wreg(4'd7, 8'hC0);
    @(negedge clk); addr = 4'd8; wdata = 8'h00; wr = 1; irq_set = 24'h000004;
    @(negedge clk); wr = 0; irq_set = 0;
    chk("R8 collision", int_id, 24'h010004);
    rreg("R6 id byte2", 4'd10, 8'h01);
    @(negedge clk); addr = 4'd7; wdata = 8'h40; wr = 1; rd = 1;
    @(negedge clk); wr = 0; rd = 0;
    chk("R10 old value", rdata, 8'hC0);
    @(negedge clk);
    chk("R10 idle", rdata, 8'h00);
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      addr = 4'($urandom_range(0, 15));
      wdata = 8'($urandom);
      wr = ($urandom_range(0, 2) == 0);
      rd = $urandom_range(0, 1) == 1;
      irq_set = ($urandom_range(0, 3) == 0) ? 24'(1 << $urandom_range(0, 23)) : 24'h0;
      pad_in = {16'($urandom), 32'($urandom)};
    end
    @(negedge clk); wr = 0; rd = 0; irq_set = 0;
    @(negedge clk);
    finish_up();
  end
endmodule